// File: doc/BRIEF.md
# Nested Interrupt Priority Resolver

This block sits between the pending-request flags of an interrupt controller and the CPU. Each cycle it looks at the vector of unmasked pending requests, together with a 3-bit priority level for each source. It picks the one request that may be offered to the CPU. Level 0 is the most urgent and level 7 the least. When two sources share a level, the one with the smaller index wins.

The block keeps an in-service record with one bit per priority level. A request is offered only when its level is strictly more urgent than every level marked in service. This lets interrupts nest only by strictly higher priority.

- An acknowledge from the CPU marks the accepted level in service.
- A return-from-interrupt pulse retires only the most urgent level that is marked.

The CPU's interrupt-enable state gates the output through a fixed settling period. After enable rises, and again after every acknowledge, a new comparison must run to completion before anything is offered. As a result, an enable window of seven clocks or fewer never yields a request.

Top module: `irq_prio_resolver`

## Requirements
- R1: While requests are pending, no level is in service and the output is settled, `req_valid_o` is high. `req_src_o` is the pending source with the numerically lowest level, `req_lvl_o` is that level, and `req_vec_o` equals 64 + 4 × source index. A change on `pend_i` or `prio_i` shows on the outputs two clock edges after it is sampled. With nothing pending, `req_valid_o` is low.
- R2: Among pending sources of equal level, the lowest source index is offered.
- R3: Bit k of `isr_o` marks level k in service. A request is offered only if no bit of `isr_o` at its own level or at any lower-numbered level is set. An equal or less urgent request stays blocked.
- R4: `ack_i` sampled high while `req_valid_o` is high sets bit `req_lvl_o` of `isr_o`. `ack_i` sampled while `req_valid_o` is low changes nothing.
- R5: `reti_i` sampled high clears only the lowest-index set bit of `isr_o`. With `isr_o` zero it has no effect.
- R6: `isr_o` has no write path. It changes only through R4 and R5.
- R7: `req_valid_o` can be high only after `int_en_i` has been sampled high on 8 consecutive edges with no accepted acknowledge among them. Any edge with `int_en_i` low restarts that count. A high window of 7 edges or fewer produces no request.
- R8: An accepted acknowledge drops `req_valid_o` at that same edge and restarts the settling count of R7, as if interrupts had been disabled.
- R9: Reset (synchronous, active high) clears `isr_o`, `req_valid_o` and the settling count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_SRC | Unmasked pending request per source |
| prio_i | input | NUM_SRC*LVL_W | Level of source i in bits [i*LVL_W +: LVL_W], 0 most urgent |
| int_en_i | input | 1 | CPU interrupt-enable state |
| ack_i | input | 1 | CPU accepts the offered request |
| reti_i | input | 1 | Return-from-interrupt pulse |
| req_valid_o | output | 1 | A request is offered to the CPU |
| req_src_o | output | SRC_W | Index of the offered source |
| req_lvl_o | output | LVL_W | Level of the offered source |
| req_vec_o | output | VEC_W | Vector of the offered source |
| isr_o | output | 2**LVL_W | Read-only in-service levels |

## Verification
Changes to the request inputs pass through a candidate register and then the output register. The bench therefore changes `pend_i`/`prio_i` and samples the outputs after the second following edge. Acknowledge and return pulses act on `isr_o` at the edge that samples them, so `isr_o` is read one cycle after the pulse.

The settling rule is checked edge by edge. The output is checked low after each of the first seven edges with enable high, or after an acknowledge. It is checked high after the eighth. All sampling happens one nanosecond after a rising edge, and inputs change at the same moment.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // width of an index over n items, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  localparam int SRC_W  = irq_prio_pkg::idx_w(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       pend_i,
  input  logic [NUM_SRC*LVL_W-1:0] prio_i,
  output logic                     any_o,
  output logic [SRC_W-1:0]         src_o,
  output logic [LVL_W-1:0]         lvl_o
);
  logic [LVL_W-1:0] lvl_a [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign lvl_a[g] = prio_i[g*LVL_W +: LVL_W];
  end

  logic             any_c;
  logic [SRC_W-1:0] src_c;
  logic [LVL_W-1:0] lvl_c;

  // strict less-than keeps the lowest index on ties
  always_comb begin
    any_c = 1'b0;
    src_c = '0;
    lvl_c = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && (!any_c || (lvl_a[i] < lvl_c))) begin
        any_c = 1'b1;
        src_c = SRC_W'(i);
        lvl_c = lvl_a[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      any_o <= 1'b0;
      src_o <= '0;
      lvl_o <= '0;
    end else begin
      any_o <= any_c;
      src_o <= src_c;
      lvl_o <= lvl_c;
    end
  end
endmodule

// File: rtl/irq_settle_timer.sv
module irq_settle_timer #(
  parameter int SETTLE = 7,
  localparam int CNT_W = irq_prio_pkg::idx_w(SETTLE + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic int_en_i,
  input  logic restart_i,
  output logic ready_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !int_en_i || restart_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign ready_o = int_en_i && !restart_i && (cnt_q == CNT_MAX);
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
  parameter int LVL_W    = 3,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_i,
  input  logic [LVL_W-1:0]   set_lvl_i,
  input  logic               clr_i,
  output logic [NUM_LVL-1:0] isr_o
);
  logic [NUM_LVL-1:0] isr_q, top_1h, set_1h, clr_m, nxt;

  always_comb begin
    top_1h = isr_q & (~isr_q + NUM_LVL'(1));
    set_1h = NUM_LVL'(1) << set_lvl_i;
    clr_m  = clr_i ? top_1h : '0;
    nxt    = (isr_q & ~clr_m) | (set_i ? set_1h : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= nxt;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int NUM_SRC    = 8,
  parameter int LVL_W      = 3,
  parameter int SETTLE     = 7,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 64,
  parameter int VEC_STRIDE = 4,
  localparam int SRC_W     = irq_prio_pkg::idx_w(NUM_SRC),
  localparam int NUM_LVL   = 1 << LVL_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       pend_i,
  input  logic [NUM_SRC*LVL_W-1:0] prio_i,
  input  logic                     int_en_i,
  input  logic                     ack_i,
  input  logic                     reti_i,
  output logic                     req_valid_o,
  output logic [SRC_W-1:0]         req_src_o,
  output logic [LVL_W-1:0]         req_lvl_o,
  output logic [VEC_W-1:0]         req_vec_o,
  output logic [NUM_LVL-1:0]       isr_o
);
  localparam logic [VEC_W-1:0] V_BASE = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] V_STEP = VEC_W'(VEC_STRIDE);

  logic             s1_any;
  logic [SRC_W-1:0] s1_src;
  logic [LVL_W-1:0] s1_lvl;
  logic             ready;
  logic             ack_ok;
  logic             valid_q;
  logic [NUM_LVL-1:0] isr;
  logic [NUM_LVL-1:0] upto;
  logic             blocked;

  assign ack_ok = ack_i && valid_q;

  irq_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_pick (
    .clk(clk), .rst(rst), .pend_i(pend_i), .prio_i(prio_i),
    .any_o(s1_any), .src_o(s1_src), .lvl_o(s1_lvl)
  );

  irq_settle_timer #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst(rst), .int_en_i(int_en_i),
    .restart_i(ack_ok), .ready_o(ready)
  );

  irq_inservice #(.LVL_W(LVL_W)) u_isr (
    .clk(clk), .rst(rst), .set_i(ack_ok), .set_lvl_i(req_lvl_o),
    .clr_i(reti_i), .isr_o(isr)
  );

  // levels at or above the candidate's urgency
  always_comb begin
    for (int j = 0; j < NUM_LVL; j++) begin
      upto[j] = (LVL_W'(j) <= s1_lvl);
    end
  end

  assign blocked = |(isr & upto);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      req_src_o <= '0;
      req_lvl_o <= '0;
      req_vec_o <= V_BASE;
    end else begin
      valid_q   <= ready && s1_any && !blocked;
      req_src_o <= s1_src;
      req_lvl_o <= s1_lvl;
      req_vec_o <= V_BASE + VEC_W'(s1_src) * V_STEP;
    end
  end

  assign req_valid_o = valid_q;
  assign isr_o       = isr;
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter int LVL_W    = 3,
  parameter int SETTLE   = 7,
  localparam int NUM_LVL = 1 << LVL_W,
  localparam int RUN_W   = irq_prio_pkg::idx_w(SETTLE + 2) + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               int_en_i,
  input logic               ack_i,
  input logic               reti_i,
  input logic               req_valid_o,
  input logic [LVL_W-1:0]   req_lvl_o,
  input logic [NUM_LVL-1:0] isr_o
);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(SETTLE + 1);

  logic [RUN_W-1:0]   run_q;
  logic [NUM_LVL-1:0] upto_m;

  always_ff @(posedge clk) begin
    if (rst || !int_en_i || (ack_i && req_valid_o)) run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + RUN_W'(1);
  end

  always_comb begin
    for (int j = 0; j < NUM_LVL; j++) upto_m[j] = (LVL_W'(j) <= req_lvl_o);
  end

  AST_SETTLE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (run_q == RUN_MAX)); // R7

  AST_NEST_STRICT: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> ((isr_o & upto_m) == '0)); // R3

  AST_ACK_SETS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (ack_i && req_valid_o) |=> isr_o[$past(req_lvl_o)]); // R4

  AST_ACK_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
    (ack_i && req_valid_o) |=> !req_valid_o); // R8

  AST_RETI_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !ack_i && (isr_o != '0)) |=>
      ($countones(isr_o) + 1 == $countones($past(isr_o)))); // R5

  AST_ISR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!ack_i && !reti_i) |=> $stable(isr_o)); // R6
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.LVL_W(LVL_W), .SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst(rst), .int_en_i(int_en_i), .ack_i(ack_i), .reti_i(reti_i),
  .req_valid_o(req_valid_o), .req_lvl_o(req_lvl_o), .isr_o(isr_o)
);

// File: tb/irq_prio_resolver_tb.sv
`timescale 1ns/1ps
module irq_prio_resolver_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pend = '0;
  logic [23:0] prio = '1;
  logic        int_en = 1'b0, ack = 1'b0, reti = 1'b0;
  logic        valid;
  logic [2:0]  src, lvl;
  logic [7:0]  vec, isr;

  int checks = 0, fails = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  irq_prio_resolver u_dut (
    .clk(clk), .rst(rst), .pend_i(pend), .prio_i(prio), .int_en_i(int_en),
    .ack_i(ack), .reti_i(reti), .req_valid_o(valid), .req_src_o(src),
    .req_lvl_o(lvl), .req_vec_o(vec), .isr_o(isr)
  );

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_lvl(input int i, input logic [2:0] l);
    prio[i*3 +: 3] = l;
  endtask

  function automatic logic [31:0] nxt_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic wait_valid();
    for (int k = 0; k < 24 && !valid; k++) step();
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    step();
    reti = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] acc;
    step(3);
    chk("R9 reset valid", 32'(valid), 0);
    chk("R9 reset isr", 32'(isr), 0);
    rst = 1'b0;
    step();

    // R7: short window and exact settling
    pend = 8'h02; set_lvl(1, 3'd2);
    step(3);
    int_en = 1'b1;
    for (int k = 0; k < 7; k++) begin
      step();
      chk("R7 short window", 32'(valid), 0);
    end
    int_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R7 after drop", 32'(valid), 0);
    end
    int_en = 1'b1;
    for (int k = 0; k < 7; k++) begin
      step();
      chk("R7 settling", 32'(valid), 0);
    end
    step();
    chk("R7 eighth edge", 32'(valid), 1);
    chk("R1 settle src", 32'(src), 1);

    // R1/R2 sweep, two-edge latency
    for (int t = 0; t < 320; t++) begin
      logic [31:0] r;
      int bs, bl;
      r = nxt_rand();
      pend = r[7:0];
      prio = (t % 4 == 0) ? {8{r[10:8]}} : nxt_rand();
      step(2);
      bs = -1; bl = 8;
      for (int i = 0; i < 8; i++)
        if (pend[i] && int'(prio[i*3 +: 3]) < bl) begin
          bs = i;
          bl = int'(prio[i*3 +: 3]);
        end
      chk((t % 4 == 0) ? "R2 tie valid" : "R1 valid", 32'(valid), (bs >= 0) ? 1 : 0);
      if (bs >= 0) begin
        chk((t % 4 == 0) ? "R2 tie src" : "R1 src", 32'(src), 32'(bs));
        chk("R1 lvl", 32'(lvl), 32'(bl));
        chk("R1 vec", 32'(vec), 32'(64 + 4 * bs));
      end
    end

    // R4/R8/R3 nesting
    pend = '0; prio = '1;
    step(3);
    pend[2] = 1'b1; set_lvl(2, 3'd4);
    wait_valid();
    chk("R1 nest src", 32'(src), 2);
    do_ack();
    pend[2] = 1'b0;
    chk("R8 valid drop", 32'(valid), 0);
    chk("R4 isr set", 32'(isr), 32'h10);
    pend[5] = 1'b1; set_lvl(5, 3'd4);
    step(12);
    chk("R3 equal blocked", 32'(valid), 0);
    set_lvl(5, 3'd5);
    step(12);
    chk("R3 lower blocked", 32'(valid), 0);
    set_lvl(5, 3'd3);
    step(2);
    chk("R3 higher nests", 32'(valid), 1);
    chk("R3 nest lvl", 32'(lvl), 3);
    pend[6] = 1'b1; set_lvl(6, 3'd1);
    do_ack();
    pend[5] = 1'b0;
    chk("R4 isr two", 32'(isr), 32'h18);
    for (int k = 0; k < 7; k++) begin
      step();
      chk("R8 resettle", 32'(valid), 0);
    end
    step();
    chk("R8 resettle end", 32'(valid), 1);
    chk("R8 resettle src", 32'(src), 6);
    do_reti();
    chk("R5 reti top", 32'(isr), 32'h10);
    pend = '0;
    do_reti();
    chk("R5 reti last", 32'(isr), 0);
    do_reti();
    chk("R5 reti empty", 32'(isr), 0);
    step(3);
    do_ack();
    chk("R4 ack ignored", 32'(isr), 0);
    step(2);
    chk("R6 isr held", 32'(isr), 0);

    // R4/R5 sweep over all levels
    acc = '0;
    for (int l = 7; l >= 0; l--) begin
      pend[0] = 1'b1; set_lvl(0, 3'(l));
      wait_valid();
      chk("R3 sweep lvl", 32'(lvl), 32'(l));
      do_ack();
      pend[0] = 1'b0;
      acc = acc | (8'h01 << l);
      chk("R4 sweep isr", 32'(isr), 32'(acc));
    end
    for (int k = 0; k < 8; k++) begin
      do_reti();
      acc = acc & (acc - 8'h01);
      chk("R5 sweep isr", 32'(isr), 32'(acc));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule